// File: doc/BRIEF.md
# Display Identification Data I2C Slave

This block lets an external bus master read and update a 256-byte table of display identification data over a two-wire I2C bus. SCL and SDA are sampled through synchronisers. SDA is driven open-drain: the block only ever pulls the line low. The slave answers one programmable address. The address compare can be narrowed to its upper 5 or 6 bits, so that one block can answer a small group of neighbouring addresses.

A write transaction starts with one byte that sets an internal byte pointer. Each data byte after it is stored at the pointer, and the pointer then advances. A read starts at the current pointer and keeps streaming bytes, advancing the pointer, for as long as the master acknowledges. A random read is a pointer write followed by a repeated START and a read. Separate write-protect bits cover the lower and upper halves of the table. A lower-half-only mode folds every access into the first 128 bytes. Two interrupt pulses, each with its own enable, report a STOP that ends a write and a repeated START. A local host port loads and inspects the table directly.

Top module: `ddc_edid_slave`

## Requirements
- R1: While `cfg_slave_en` is 0 the block never pulls SDA low, so every address byte is answered with NACK.
- R2: With a 7-bit compare (`cfg_addr_len` = 00), the block acknowledges an address byte whose upper seven bits equal `cfg_addr` and rejects any other address.
- R3: `cfg_addr_len` = 01 compares only address bits 6:1, and `cfg_addr_len` = 10 compares only bits 6:2. The remaining low bits are don't-care.
- R4: In a write, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then advances by one modulo 256 (0xFF wraps to 0x00).
- R5: When `cfg_wen_lo` is 0, bus writes to locations 0x00-0x7F are acknowledged but leave the memory unchanged.
- R6: When `cfg_wen_hi` is 0, bus writes to locations 0x80-0xFF are acknowledged but leave the memory unchanged.
- R7: When `cfg_lo_only` is 1, the loaded pointer has bit 7 cleared and advances modulo 128 (0x7F wraps to 0x00), for both reads and writes.
- R8: A read returns the byte at the pointer MSB first and advances the pointer after each byte, so a random read followed by acknowledged reads yields consecutive locations.
- R9: After the master NACKs a read byte, the block keeps SDA released until the next STOP or START. SDA changes only while the synchronised SCL is low.
- R10: A STOP that ends a write transaction addressed to this block raises `irq_wstop` for exactly one cycle if `cfg_irq_wstop_en` is 1. A read transaction, or a cleared enable, raises no pulse.
- R11: A START seen while the bus is already busy raises `irq_rstart` for one cycle if `cfg_irq_rstart_en` is 1.
- R12: The host port writes a byte when `host_we` is 1, and `host_rdata` shows the byte at `host_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_slave_en | input | 1 | Block enable |
| cfg_addr | input | 7 | Slave address |
| cfg_addr_len | input | 2 | Compare width: 00 7-bit, 01 6-bit, 10 5-bit |
| cfg_wen_lo | input | 1 | Bus write enable for 0x00-0x7F |
| cfg_wen_hi | input | 1 | Bus write enable for 0x80-0xFF |
| cfg_lo_only | input | 1 | Confine accesses to the lower half |
| cfg_irq_wstop_en | input | 1 | Enable for the write-STOP interrupt |
| cfg_irq_rstart_en | input | 1 | Enable for the repeated-START interrupt |
| irq_wstop | output | 1 | Write-ended-by-STOP pulse |
| irq_rstart | output | 1 | Repeated-START pulse |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |

## Verification
The assertions assume that the configuration inputs hold steady while a transaction is in progress. They also assume the master changes SDA only while SCL is low, except to form START and STOP, and that each SCL phase lasts longer than the synchroniser delay. The bench master uses quarter-bit phases of eight clocks. It changes the configuration only between a STOP and the next START, and it never forms a STOP or START while the slave is holding SDA low.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int PTR_W = 8;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
  } slv_state_e;

  // Compare the received address with the programmed one at the chosen width.
  function automatic logic addr_hit(input logic [6:0] rx, input logic [6:0] own,
                                    input logic [1:0] len);
    case (len)
      2'b10:   return rx[6:2] == own[6:2];
      2'b01:   return rx[6:1] == own[6:1];
      default: return rx == own;
    endcase
  endfunction

  // Pointer value after folding into the lower half when that mode is on.
  function automatic logic [PTR_W-1:0] ptr_fold(input logic [PTR_W-1:0] v, input logic lo);
    return lo ? {1'b0, v[PTR_W-2:0]} : v;
  endfunction

  // Next pointer value, modulo the active window.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input logic lo);
    logic [PTR_W-1:0] n;
    n = p + 1'b1;
    return ptr_fold(n, lo);
  endfunction

  // Write permission for a location from the two half enables.
  function automatic logic wr_allowed(input logic [PTR_W-1:0] a, input logic wl, input logic wh);
    return a[PTR_W-1] ? wh : wl;
  endfunction
endpackage

// File: rtl/ddc_bus_sync.sv
module ddc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
  assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ddc_ram.sv
module ddc_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          slv_we,
  input  logic [AW-1:0] slv_waddr,
  input  logic [DW-1:0] slv_wdata,
  input  logic [AW-1:0] slv_raddr,
  output logic [DW-1:0] slv_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // Host port takes priority on a same-cycle collision.
  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wdata;
    else if (slv_we) mem[slv_waddr] <= slv_wdata;
  end

  assign host_rdata = mem[host_addr];
  assign slv_rdata  = mem[slv_raddr];
endmodule

// File: rtl/ddc_slave_fsm.sv
module ddc_slave_fsm
  import ddc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [6:0]        cfg_addr,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_wen_lo,
  input  logic              cfg_wen_hi,
  input  logic              cfg_lo_only,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ev_addr_hit,
  output logic              ev_wstop,
  output logic              ev_rstart
);
  slv_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic [PTR_W-1:0]  ptr, ptr_eff;
  logic              rnw, first_byte, wr_txn, master_ack, bus_busy;

  assign ptr_eff = ptr_fold(ptr, cfg_lo_only);
  assign rd_addr = ptr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      txreg       <= '0;
      ptr         <= '0;
      rnw         <= 1'b0;
      first_byte  <= 1'b0;
      wr_txn      <= 1'b0;
      master_ack  <= 1'b0;
      bus_busy    <= 1'b0;
      sda_oe      <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      ev_addr_hit <= 1'b0;
      ev_wstop    <= 1'b0;
      ev_rstart   <= 1'b0;
    end else begin
      wr_en       <= 1'b0;
      ev_addr_hit <= 1'b0;
      ev_wstop    <= 1'b0;
      ev_rstart   <= 1'b0;
      if (ev_start) begin
        ev_rstart <= bus_busy;
        bus_busy  <= 1'b1;
        state     <= ST_ADDR;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        wr_txn    <= 1'b0;
      end else if (ev_stop) begin
        ev_wstop <= wr_txn;
        bus_busy <= 1'b0;
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        wr_txn   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (cfg_en && addr_hit(shreg[7:1], cfg_addr, cfg_len)) begin
                sda_oe      <= 1'b1;
                rnw         <= shreg[0];
                ev_addr_hit <= 1'b1;
                state       <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rnw) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= ST_RD;
              end else begin
                sda_oe     <= 1'b0;
                first_byte <= 1'b1;
                wr_txn     <= 1'b1;
                state      <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              if (first_byte) begin
                ptr        <= ptr_fold(shreg, cfg_lo_only);
                first_byte <= 1'b0;
              end else begin
                if (wr_allowed(ptr_eff, cfg_wen_lo, cfg_wen_hi)) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_eff;
                  wr_data <= shreg;
                end
                ptr <= ptr_step(ptr_eff, cfg_lo_only);
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                ptr    <= ptr_step(ptr_eff, cfg_lo_only);
                state  <= ST_RD_ACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (master_ack) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                bitcnt <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddc_edid_slave.sv
module ddc_edid_slave
  import ddc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cfg_slave_en,
  input  logic [6:0]        cfg_addr,
  input  logic [1:0]        cfg_addr_len,
  input  logic              cfg_wen_lo,
  input  logic              cfg_wen_hi,
  input  logic              cfg_lo_only,
  input  logic              cfg_irq_wstop_en,
  input  logic              cfg_irq_rstart_en,
  output logic              irq_wstop,
  output logic              irq_rstart,
  input  logic              host_we,
  input  logic [PTR_W-1:0]  host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic ev_addr_hit, ev_wstop, ev_rstart;
  logic slv_we;
  logic [PTR_W-1:0]  slv_waddr, slv_raddr;
  logic [BYTE_W-1:0] slv_wdata, slv_rdata;

  ddc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  ddc_slave_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_slave_en), .cfg_addr(cfg_addr), .cfg_len(cfg_addr_len),
    .cfg_wen_lo(cfg_wen_lo), .cfg_wen_hi(cfg_wen_hi), .cfg_lo_only(cfg_lo_only),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .rd_data(slv_rdata),
    .sda_oe(sda_oe), .rd_addr(slv_raddr),
    .wr_en(slv_we), .wr_addr(slv_waddr), .wr_data(slv_wdata),
    .ev_addr_hit(ev_addr_hit), .ev_wstop(ev_wstop), .ev_rstart(ev_rstart)
  );

  ddc_ram #(.AW(PTR_W), .DW(BYTE_W)) u_ram (
    .clk(clk),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .slv_we(slv_we), .slv_waddr(slv_waddr), .slv_wdata(slv_wdata),
    .slv_raddr(slv_raddr), .slv_rdata(slv_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_wstop  <= 1'b0;
      irq_rstart <= 1'b0;
    end else begin
      irq_wstop  <= ev_wstop & cfg_irq_wstop_en;
      irq_rstart <= ev_rstart & cfg_irq_rstart_en;
    end
  end
endmodule

// File: rtl/ddc_edid_slave_chk.sv
module ddc_edid_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_slave_en,
  input logic       cfg_wen_lo,
  input logic       cfg_wen_hi,
  input logic       cfg_lo_only,
  input logic       cfg_irq_wstop_en,
  input logic       irq_wstop,
  input logic       irq_rstart,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       ev_start,
  input logic       ev_addr_hit,
  input logic       slv_we,
  input logic [7:0] slv_waddr
);
  a_r1_no_hit_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_hit |-> $past(cfg_slave_en));

  a_r5_lo_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_we && !slv_waddr[7]) |-> $past(cfg_wen_lo));

  a_r6_hi_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_we && slv_waddr[7]) |-> $past(cfg_wen_hi));

  a_r7_lo_only_window: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_we && $past(cfg_lo_only)) |-> !slv_waddr[7]);

  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r10_wstop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wstop |=> !irq_wstop);

  a_r10_wstop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wstop |-> $past(cfg_irq_wstop_en));

  a_r11_rstart_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rstart |-> $past(ev_start, 2));
endmodule

bind ddc_edid_slave ddc_edid_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_slave_en(cfg_slave_en),
  .cfg_wen_lo(cfg_wen_lo), .cfg_wen_hi(cfg_wen_hi), .cfg_lo_only(cfg_lo_only),
  .cfg_irq_wstop_en(cfg_irq_wstop_en), .irq_wstop(irq_wstop), .irq_rstart(irq_rstart),
  .sda_oe(sda_oe), .scl_s(scl_s), .ev_start(ev_start), .ev_addr_hit(ev_addr_hit),
  .slv_we(slv_we), .slv_waddr(slv_waddr)
);

// File: tb/ddc_edid_slave_tb.sv
module ddc_edid_slave_tb;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic en = 1'b0, wlo = 1'b1, whi = 1'b1, lo = 1'b0, iew = 1'b1, ier = 1'b1;
  logic [6:0] own = 7'h50;
  logic [1:0] len = 2'b00;
  logic irq_wstop, irq_rstart;
  logic host_we = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00, host_rdata;

  assign sda_line = sda_m & ~sda_oe;

  ddc_edid_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_slave_en(en), .cfg_addr(own), .cfg_addr_len(len),
    .cfg_wen_lo(wlo), .cfg_wen_hi(whi), .cfg_lo_only(lo),
    .cfg_irq_wstop_en(iew), .cfg_irq_rstart_en(ier),
    .irq_wstop(irq_wstop), .irq_rstart(irq_rstart),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  int checks = 0, failures = 0;
  int n_wstop = 0, n_rstart = 0;
  bit done = 0;
  bit quiet_mon = 0;
  int quiet_bad = 0;
  logic [7:0] exp_mem [256];
  int mp = 0;

  // Per-clock observation of the outputs, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_wstop) n_wstop++;
      if (irq_rstart) n_rstart++;
      if (quiet_mon && sda_oe) quiet_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T);
    sda_m = 1'b0; tick(T); scl_m = 1'b0; tick(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(T); scl_m = 1'b1; tick(T); sda_m = 1'b1; tick(2*T);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(T); scl_m = 1'b1; tick(2*T); scl_m = 1'b0; tick(T);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T); b = sda_line;
    tick(T); scl_m = 1'b0; tick(T);
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(nb);
    ack = !nb;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!ack);
  endtask

  function automatic bit model_hit(input logic [6:0] a);
    logic [6:0] m;
    m = (len == 2'b10) ? 7'b1111100 : (len == 2'b01) ? 7'b1111110 : 7'b1111111;
    return en && (((a ^ own) & m) == 7'd0);
  endfunction

  function automatic int model_wrap(input int p);
    return lo ? (p % 128) : (p % 256);
  endfunction

  // Write transaction: pointer byte then n data bytes; updates the model.
  task automatic do_write(input logic [6:0] dev, input logic [7:0] p, input int n,
                          input logic [7:0] d [3], output bit all_ack);
    bit a;
    bus_start();
    wr_byte({dev, 1'b0}, a); all_ack = a;
    wr_byte(p, a); all_ack &= a;
    mp = model_wrap(p);
    for (int k = 0; k < n; k++) begin
      wr_byte(d[k], a); all_ack &= a;
      if (mp < 128 ? wlo : whi) exp_mem[mp] = d[k];
      mp = model_wrap(mp + 1);
    end
    bus_stop();
  endtask

  // Random read of n bytes starting at p; NACKs the last byte.
  task automatic do_read(input logic [6:0] dev, input logic [7:0] p, input int n,
                         output logic [7:0] r [4], output bit ok_ack);
    bit a;
    bus_start();
    wr_byte({dev, 1'b0}, a); ok_ack = a;
    wr_byte(p, a); ok_ack &= a;
    bus_start();
    wr_byte({dev, 1'b1}, a); ok_ack &= a;
    for (int k = 0; k < n; k++) rd_byte(k != n - 1, r[k]);
    quiet_mon = 1; tick(3*T); quiet_mon = 0;
    bus_stop();
  endtask

  task automatic addr_probe(input logic [6:0] dev, input string req);
    bit a;
    bus_start();
    wr_byte({dev, 1'b0}, a);
    bus_stop();
    chk(a == model_hit(dev), req, $sformatf("ack for address %0h", dev), a, model_hit(dev));
  endtask

  task automatic scan(input string req);
    int bad = 0, first_a = -1, act = 0, expv = 0;
    for (int i = 0; i < 256; i++) begin
      host_addr = i[7:0]; tick(1);
      if (host_rdata !== exp_mem[i]) begin
        if (first_a < 0) begin first_a = i; act = host_rdata; expv = exp_mem[i]; end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("memory scan first bad addr %0h", first_a), act, expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [3];
    logic [7:0] r [4];
    bit a;
    int w0, r0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    chk(sda_oe == 1'b0 && irq_wstop == 1'b0 && irq_rstart == 1'b0, "reset",
        "outputs idle", {sda_oe, irq_wstop, irq_rstart}, 0);

    // R12: host preload and readback.
    for (int i = 0; i < 256; i++) begin
      exp_mem[i] = 8'((i * 7 + 3) & 255);
      host_we = 1'b1; host_addr = i[7:0]; host_wdata = exp_mem[i]; tick(1);
    end
    host_we = 1'b0;
    scan("R12");

    // R1: disabled block never acknowledges.
    en = 1'b0;
    quiet_bad = 0; quiet_mon = 1;
    addr_probe(7'h50, "R1");
    quiet_mon = 0;
    chk(quiet_bad == 0, "R1", "sda driven while disabled", quiet_bad, 0);

    // R2: 7-bit compare.
    en = 1'b1; len = 2'b00;
    addr_probe(7'h50, "R2");
    addr_probe(7'h51, "R2");

    // R3: narrower compares.
    len = 2'b01;
    addr_probe(7'h51, "R3");
    addr_probe(7'h52, "R3");
    len = 2'b10;
    addr_probe(7'h53, "R3");
    addr_probe(7'h54, "R3");
    len = 2'b00;

    // R4 + R10: write wrapping across 0xFF.
    d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3;
    w0 = n_wstop;
    do_write(7'h50, 8'hFE, 3, d, a);
    tick(4);
    chk(a, "R4", "write acknowledged", a, 1);
    chk(n_wstop == w0 + 1, "R10", "wstop pulses after write", n_wstop - w0, 1);
    scan("R4");

    // R8 + R11 + R9 + R10: random then sequential read across the wrap.
    w0 = n_wstop; r0 = n_rstart; quiet_bad = 0;
    do_read(7'h50, 8'hFE, 3, r, a);
    tick(4);
    chk(a, "R8", "read addressing acknowledged", a, 1);
    for (int k = 0; k < 3; k++)
      chk(r[k] == exp_mem[(254 + k) % 256], "R8", $sformatf("read byte %0d", k),
          r[k], exp_mem[(254 + k) % 256]);
    chk(n_rstart == r0 + 1, "R11", "rstart pulses", n_rstart - r0, 1);
    chk(n_wstop == w0, "R10", "no wstop after read", n_wstop - w0, 0);
    chk(quiet_bad == 0, "R9", "sda driven after master NACK", quiet_bad, 0);

    // R10/R11 with enables cleared.
    iew = 1'b0; ier = 1'b0;
    w0 = n_wstop; r0 = n_rstart;
    d[0] = 8'h11;
    do_write(7'h50, 8'h20, 1, d, a);
    do_read(7'h50, 8'h20, 1, r, a);
    tick(4);
    chk(n_wstop == w0, "R10", "wstop with enable off", n_wstop - w0, 0);
    chk(n_rstart == r0, "R11", "rstart with enable off", n_rstart - r0, 0);
    chk(r[0] == 8'h11, "R4", "single byte readback", r[0], 8'h11);
    iew = 1'b1; ier = 1'b1;

    // R5: lower half protected.
    wlo = 1'b0;
    d[0] = 8'h5A; d[1] = 8'h5B;
    do_write(7'h50, 8'h10, 2, d, a);
    chk(a, "R5", "protected write still acknowledged", a, 1);
    scan("R5");
    wlo = 1'b1;

    // R6: upper half protected.
    whi = 1'b0;
    d[0] = 8'h6A; d[1] = 8'h6B;
    do_write(7'h50, 8'h90, 2, d, a);
    chk(a, "R6", "protected write still acknowledged", a, 1);
    scan("R6");
    whi = 1'b1;

    // R7: lower-half-only window.
    lo = 1'b1;
    d[0] = 8'h77; d[1] = 8'h88;
    do_write(7'h50, 8'hFF, 2, d, a);
    scan("R7");
    do_read(7'h50, 8'h7E, 3, r, a);
    for (int k = 0; k < 3; k++)
      chk(r[k] == exp_mem[(126 + k) % 128], "R7", $sformatf("folded read %0d", k),
          r[k], exp_mem[(126 + k) % 128]);
    lo = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule